// File: doc/BRIEF.md
# Programmable-Depth Pulse Width Modulator

This block produces one pulse-width-modulated output from two 32-bit control words written over a plain request port. The request port carries valid, write, a one-bit word select and write data. A prescaler divides the clock by a programmable amount to form ticks. The ticks advance a period counter, and the period length is programmable. The output is high for the first `duty` counts of every period and low for the rest.

A build parameter picks one of two layouts. In the wide layout, word 0 holds duty and scale and word 1 holds the enable and the depth. In the compatible layout:
- the period is fixed at 256 counts;
- duty is eight bits wide;
- the enable bit sits in word 0;
- a separate bit forces full duty;
- word 1 is absent.

Duty, scale and depth are copied into working copies only while the block is stopped or when a period wraps. A change made while the block runs therefore never cuts a pulse short.

Top module: `pwm_gen`

## Requirements
- R1: Word 0 (req_addr=0) and, in the wide layout, word 1 (req_addr=1) are written by a cycle with req_valid=1 and req_write=1. Both read back on rsp_rdata as written whenever req_addr selects them. Both are zero after reset, and pwm_out is 0 after reset.
- R2: Scale is word 0 bits 15:0. Each period count lasts (scale+1) clock cycles.
- R3: In the wide layout, depth is word 1 bits 30:15 and duty is word 0 bits 31:16. A period is (depth+1) counts, and the output is high for the first duty counts of it. With scale 0 the period is (depth+1) cycles, which is the fastest rate the block can produce.
- R4: A duty of 0 keeps pwm_out low throughout.
- R5: A duty of at least depth+1 keeps pwm_out high for the whole period.
- R6: The enable is word 1 bit 31 in the wide layout (1 = run). The output starts one cycle after the write that sets enable, beginning at count 0 of a period. Clearing enable drives pwm_out low one cycle after the write and returns both counters to zero, so the next start begins a fresh period.
- R7: Duty, scale or depth written while the block runs take effect only at the next period boundary.
- R8: In the compatible layout, the period is fixed at 256 counts, duty is word 0 bits 23:16, and the enable is word 0 bit 31. Word 0 bits 30:25 have no effect on the output.
- R9: In the compatible layout, word 0 bit 24 set forces the output high for the whole period, and duty bits 23:16 are then ignored.
- R10: In the compatible layout, word 1 reads as zero and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | Control word select |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data of the selected word |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest case to reach is a duty change that lands in the middle of a running period. The new value must not appear until the counter wraps. The bench starts the generator and issues the write on the cycle right after the period begins. It then compares every following cycle against the old duty for the rest of that period and against the new duty for the next period. The compatible layout uses a second instance to reach the forced-full bit, the ignored upper bits of word 0 and the dead word 1.

// File: rtl/pwm_gen.sv
module pwm_gen #(
  parameter bit LEGACY = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  output logic        pwm_out
);
  localparam int CW = 16;
  localparam int DW = CW + 1;

  logic [31:0]   csr0, csr1;
  logic          run;
  logic [CW-1:0] pre_cnt, per_cnt;
  logic [CW-1:0] act_scale, act_depth;
  logic [DW-1:0] act_duty;
  logic          cfg_en;
  logic [CW-1:0] cfg_depth, cfg_scale;
  logic [DW-1:0] cfg_duty;
  logic          tick;

  wire wr0 = req_valid && req_write && !req_addr;
  wire wr1 = req_valid && req_write &&  req_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   csr0 <= '0;
    else if (wr0) csr0 <= req_wdata;

  generate
    if (LEGACY) begin : g_compat
      assign csr1      = '0;
      assign cfg_en    = csr0[31];
      assign cfg_depth = CW'(255);
      assign cfg_duty  = csr0[24] ? DW'(256) : DW'(csr0[23:16]);
    end else begin : g_wide
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)   csr1 <= '0;
        else if (wr1) csr1 <= req_wdata;
      assign cfg_en    = csr1[31];
      assign cfg_depth = csr1[30:15];
      assign cfg_duty  = {1'b0, csr0[31:16]};
    end
  endgenerate

  assign cfg_scale = csr0[15:0];
  assign rsp_rdata = req_addr ? csr1 : csr0;
  assign tick      = (pre_cnt == act_scale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      pre_cnt   <= '0;
      per_cnt   <= '0;
      act_scale <= '0;
      act_depth <= '0;
      act_duty  <= '0;
    end else begin
      run <= cfg_en;
      if (!run) begin
        pre_cnt   <= '0;
        per_cnt   <= '0;
        act_scale <= cfg_scale;
        act_depth <= cfg_depth;
        act_duty  <= cfg_duty;
      end else if (tick) begin
        pre_cnt <= '0;
        if (per_cnt == act_depth) begin
          per_cnt   <= '0;
          act_scale <= cfg_scale;
          act_depth <= cfg_depth;
          act_duty  <= cfg_duty;
        end else begin
          per_cnt <= per_cnt + 1'b1;
        end
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  assign pwm_out = run && ({1'b0, per_cnt} < act_duty);
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [15:0] pre_cnt,
  input logic [15:0] per_cnt,
  input logic [15:0] act_scale,
  input logic [15:0] act_depth,
  input logic [16:0] act_duty,
  input logic        pwm_out
);
  wire wrap = (pre_cnt == act_scale) && (per_cnt == act_depth);

  p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !pwm_out);
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (per_cnt == 16'd0 && pre_cnt == 16'd0));
  p_duty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_duty == 17'd0) |-> !pwm_out);
  p_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_duty > {1'b0, act_depth}) |-> pwm_out);
  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (per_cnt <= act_depth));
  p_prescale_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pre_cnt != act_scale) |=> (!run || $stable(per_cnt)));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(act_duty) && $stable(act_depth) && $stable(act_scale)));
endmodule

bind pwm_gen pwm_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pre_cnt(pre_cnt), .per_cnt(per_cnt),
  .act_scale(act_scale), .act_depth(act_depth), .act_duty(act_duty),
  .pwm_out(pwm_out)
);

// File: tb/tb_pwm_gen.sv
module tb_pwm_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v_e = 1'b0, v_l = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_e, rd_l;
  logic out_e, out_l;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pwm_gen #(.LEGACY(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(v_e), .req_write(wr), .req_addr(addr),
    .req_wdata(wdata), .rsp_rdata(rd_e), .pwm_out(out_e));
  pwm_gen #(.LEGACY(1'b1)) dut_leg (
    .clk(clk), .rst_n(rst_n), .req_valid(v_l), .req_write(wr), .req_addr(addr),
    .req_wdata(wdata), .rsp_rdata(rd_l), .pwm_out(out_l));

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input bit leg, input bit a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    if (leg) v_l = 1'b1; else v_e = 1'b1;
    @(posedge clk);
    @(negedge clk);
    v_l = 1'b0; v_e = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_chk(input bit leg, input bit a, input logic [31:0] exp, input string tag);
    addr = a;
    #0.5;
    chk((leg ? rd_l : rd_e) == exp, tag, leg ? rd_l : rd_e, exp);
  endtask

  task automatic wave_chk(input bit leg, input int n, input int s, input int d,
                          input int duty, input string tag);
    int errs = 0;
    int bad_i = -1;
    for (int i = 0; i < n; i++) begin
      bit exp = ((i / (s + 1)) % (d + 1)) < duty;
      bit act = leg ? out_l : out_e;
      if (act != exp) begin
        errs++;
        if (bad_i < 0) bad_i = i;
      end
      @(negedge clk);
    end
    chk(errs == 0, $sformatf("%s (mismatched samples, first at %0d)", tag, bad_i), errs, 0);
  endtask

  function automatic logic [31:0] w0(input int duty, input int scale);
    return {duty[15:0], scale[15:0]};
  endfunction

  task automatic start_e(input int depth);
    bus_wr(0, 1'b1, {1'b1, depth[15:0], 15'd0});
    @(negedge clk);
  endtask

  task automatic stop_e();
    bus_wr(0, 1'b1, 32'd0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(out_e == 1'b0 && out_l == 1'b0, "R1 reset output", {out_e, out_l}, 0);
    rd_chk(0, 1'b0, 32'd0, "R1 reset word0");
    rd_chk(0, 1'b1, 32'd0, "R1 reset word1");
  endtask

  task automatic t_readback();
    bus_wr(0, 1'b0, 32'h1234_5678);
    bus_wr(0, 1'b1, 32'h0000_8000);
    rd_chk(0, 1'b0, 32'h1234_5678, "R1 word0 readback");
    rd_chk(0, 1'b1, 32'h0000_8000, "R1 word1 readback");
    chk(out_e == 1'b0, "R6 idle while enable clear", out_e, 0);
  endtask

  task automatic t_ratio();
    bus_wr(0, 1'b0, w0(3, 0));
    start_e(9);
    wave_chk(0, 40, 0, 9, 3, "R3 duty 3 of 10");
    stop_e();
  endtask

  task automatic t_scale();
    bus_wr(0, 1'b0, w0(1, 2));
    start_e(3);
    wave_chk(0, 48, 2, 3, 1, "R2 scale 2");
    stop_e();
  endtask

  task automatic t_zero();
    bus_wr(0, 1'b0, w0(0, 0));
    start_e(4);
    wave_chk(0, 20, 0, 4, 0, "R4 zero duty");
    stop_e();
  endtask

  task automatic t_full();
    bus_wr(0, 1'b0, w0(9, 1));
    start_e(3);
    wave_chk(0, 24, 1, 3, 9, "R5 duty above period");
    stop_e();
  endtask

  task automatic t_disable();
    bus_wr(0, 1'b0, w0(20, 0));
    start_e(3);
    wave_chk(0, 3, 0, 3, 20, "R6 running high");
    bus_wr(0, 1'b1, 32'd0);
    @(negedge clk);
    wave_chk(0, 6, 0, 3, 0, "R6 low after disable");
    bus_wr(0, 1'b0, w0(2, 1));
    start_e(3);
    wave_chk(0, 16, 1, 3, 2, "R6 restart from count 0");
    stop_e();
  endtask

  task automatic t_boundary();
    bus_wr(0, 1'b0, w0(2, 0));
    start_e(7);
    bus_wr(0, 1'b0, w0(6, 0));
    begin
      int hi = 0;
      for (int i = 0; i < 7; i++) begin
        hi += out_e;
        @(negedge clk);
      end
      chk(hi == 1, "R7 old duty kept to end of period", hi, 1);
    end
    wave_chk(0, 16, 0, 7, 6, "R7 new duty from next period");
    stop_e();
  endtask

  task automatic t_leg_ratio();
    bus_wr(1, 1'b0, 32'h8000_0000 | (32'h3E << 25) | (32'd64 << 16));
    @(negedge clk);
    wave_chk(1, 512, 0, 255, 64, "R8 fixed 256 period, upper bits ignored");
    bus_wr(1, 1'b0, 32'd0);
    @(negedge clk);
    chk(out_l == 1'b0, "R8 enable in word0 stops output", out_l, 0);
  endtask

  task automatic t_leg_force();
    bus_wr(1, 1'b0, 32'h8000_0000 | (32'd1 << 24) | (32'h10 << 16) | 32'd1);
    @(negedge clk);
    wave_chk(1, 520, 1, 255, 256, "R9 forced full duty");
    bus_wr(1, 1'b0, 32'd0);
    @(negedge clk);
  endtask

  task automatic t_leg_word1();
    bus_wr(1, 1'b0, 32'h0080_0000);
    bus_wr(1, 1'b1, 32'hFFFF_FFFF);
    rd_chk(1, 1'b1, 32'd0, "R10 word1 reads zero");
    wave_chk(1, 10, 0, 255, 0, "R10 word1 enable has no effect");
    rd_chk(1, 1'b0, 32'h0080_0000, "R10 word0 untouched");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_ratio();
    t_scale();
    t_zero();
    t_full();
    t_disable();
    t_boundary();
    t_leg_ratio();
    t_leg_force();
    t_leg_word1();
    summary();
    $finish;
  end
endmodule